// File: doc/BRIEF.md
# Hexadecimal Floating-Point Operand Alignment Stage

This block is the front stage of a base-16 floating-point adder. Each operand has a sign bit, a 7-bit characteristic and a 56-bit fraction. The characteristic holds a power of sixteen with a bias of 64. The fraction holds 14 hex digits, and its radix point sits above the most significant digit. An add/subtract opcode bit comes with each operand pair. The block finds out which operand has the smaller characteristic. It shifts that operand's fraction right by whole hex digits until both characteristics match. The other fraction goes through true/complement gating, ready for a downstream end-around-carry fraction adder.

The characteristics are compared by adding characteristic A to the bitwise inverse of characteristic B, with the carry-out fed back into the low bit. The carry-out does two jobs: it chooses which fraction is shifted, and it chooses whether the sum or its inverse is the digit count. A sum of all ones (equal characteristics) is handled as the carry case. Digit counts above 14 are forced to 15, which empties the shifted fraction. The right shift is done in two levels, first by 0 to 3 digits and then by 0, 4, 8 or 12 digits. Shifted-out digits are dropped.

Every output is registered, and a new operand pair may be presented on every cycle.

Top module: `hexfp_align`

## Requirements
- R1: `out_valid_o` goes high in the cycle after a clock edge that sampled `in_valid_i` high, and goes low after an edge that sampled it low.
- R2: `eff_sub_o` equals sign A XOR sign B XOR `sub_op_i` of the captured pair (1 = subtract).
- R3: `res_char_o` equals the larger of the two captured characteristics.
- R4: When characteristic A is greater than characteristic B, `aligned_frac_o` is fraction B shifted right by (A - B) hex digits, and the gated fraction is built from fraction A.
- R5: When characteristic B is greater than characteristic A, `aligned_frac_o` is fraction A shifted right by (B - A) hex digits, and the gated fraction is built from fraction B.
- R6: When the characteristics are equal, `aligned_frac_o` is fraction B unshifted, and the gated fraction is built from fraction A.
- R7: When the characteristics differ by more than 14, `aligned_frac_o` is all zeros.
- R8: `gated_frac_o` is the bitwise inverse of the unshifted fraction when the effective operation is subtract, and that fraction unchanged otherwise.
- R9: An edge that samples `in_valid_i` low leaves `aligned_frac_o`, `gated_frac_o`, `res_char_o` and `eff_sub_o` unchanged.
- R10: While `rst_ni` is low, every output is zero.
- R11: Pairs presented on consecutive cycles each produce their own result, one cycle apart, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair present |
| sub_op_i | input | 1 | Opcode subtract bit |
| sign_a_i | input | 1 | Sign of operand A |
| char_a_i | input | 7 | Characteristic of A, bias 64 |
| frac_a_i | input | 56 | Fraction of A, 14 hex digits |
| sign_b_i | input | 1 | Sign of operand B |
| char_b_i | input | 7 | Characteristic of B, bias 64 |
| frac_b_i | input | 56 | Fraction of B, 14 hex digits |
| out_valid_o | output | 1 | Registered result valid |
| aligned_frac_o | output | 56 | Right-shifted fraction |
| gated_frac_o | output | 56 | True/complement gated unshifted fraction |
| res_char_o | output | 7 | Tentative result characteristic |
| eff_sub_o | output | 1 | Effective subtract |

## Verification
Any internal fault shows up on the outputs one cycle after the faulty pair is sampled, because only one register stage exists. A wrong end-around-carry result or a wrong carry polarity picks the wrong fraction, or gives a shift count off by one. That shows as a swapped `res_char_o` or a mis-aligned fraction, and it is most visible at equal characteristics and at differences of 1, 14 and 15. A fault in either shifter level breaks only the digit counts that use that level. For that reason the random stimulus is biased toward small differences, so that every count from 0 to 15 is exercised.

// File: rtl/hexfp_align_pkg.sv
package hexfp_align_pkg;
  parameter int unsigned DIGITS = 14;
  parameter int unsigned CHAR_W = 7;
  localparam int unsigned FRAC_W = DIGITS * 4;
  localparam int unsigned SH_W   = $clog2(DIGITS + 1);
endpackage

// File: rtl/hexfp_exp_cmp.sv
module hexfp_exp_cmp #(
  parameter int unsigned CHAR_W = 7,
  parameter int unsigned DIGITS = 14,
  parameter int unsigned SH_W   = 4
) (
  input  logic [CHAR_W-1:0] char_a_i,
  input  logic [CHAR_W-1:0] char_b_n_i,  // already inverted at entry
  output logic              a_ge_b_o,
  output logic [SH_W-1:0]   shamt_o
);
  localparam logic [SH_W-1:0] MAX_SH = '1;

  logic [CHAR_W:0]   raw;
  logic              cout;
  logic [CHAR_W-1:0] sum;
  logic [CHAR_W-1:0] eac_sum;
  logic [CHAR_W-1:0] mag;
  logic              neg_zero;

  assign raw      = {1'b0, char_a_i} + {1'b0, char_b_n_i};
  assign cout     = raw[CHAR_W];
  assign sum      = raw[CHAR_W-1:0];
  assign eac_sum  = sum + CHAR_W'(cout);
  assign neg_zero = &sum;
  // all-ones sum is ones-complement zero: route to the A>=B path
  assign a_ge_b_o = cout | neg_zero;
  assign mag      = cout ? eac_sum : ~sum;
  assign shamt_o  = (mag > CHAR_W'(DIGITS)) ? MAX_SH : mag[SH_W-1:0];
endmodule

// File: rtl/hexfp_digit_rshift.sv
module hexfp_digit_rshift #(
  parameter int unsigned DIGITS = 14,
  parameter int unsigned SH_W   = 4
) (
  input  logic [DIGITS*4-1:0] din_i,
  input  logic [SH_W-1:0]     shamt_i,
  output logic [DIGITS*4-1:0] dout_o
);
  localparam int unsigned HI_W  = SH_W - 2;
  localparam int unsigned PAD1  = 3;
  localparam int unsigned PAD2  = 4 * ((1 << HI_W) - 1);
  localparam int unsigned N1    = DIGITS + PAD1;
  localparam int unsigned N2    = DIGITS + PAD2;
  localparam int unsigned IW1   = $clog2(N1);
  localparam int unsigned IW2   = $clog2(N2);

  logic [3:0] pad1 [N1];
  logic [3:0] pad2 [N2];

  for (genvar j = 0; j < N1; j++) begin : g_pad1
    if (j < DIGITS) begin : g_d
      assign pad1[j] = din_i[4*j +: 4];
    end else begin : g_z
      assign pad1[j] = 4'h0;
    end
  end

  // level 1: 0..3 digits
  for (genvar j = 0; j < N2; j++) begin : g_lvl1
    if (j < DIGITS) begin : g_d
      logic [IW1-1:0] idx;
      assign idx     = IW1'(j) + IW1'(shamt_i[1:0]);
      assign pad2[j] = pad1[idx];
    end else begin : g_z
      assign pad2[j] = 4'h0;
    end
  end

  // level 2: 0,4,8,12 digits
  for (genvar j = 0; j < DIGITS; j++) begin : g_lvl2
    logic [IW2-1:0] idx;
    assign idx             = IW2'(j) + (IW2'(shamt_i[SH_W-1:2]) << 2);
    assign dout_o[4*j +: 4] = pad2[idx];
  end
endmodule

// File: rtl/hexfp_tc_gate.sv
module hexfp_tc_gate #(
  parameter int unsigned FRAC_W = 56
) (
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              inv_i,
  output logic [FRAC_W-1:0] frac_o
);
  assign frac_o = frac_i ^ {FRAC_W{inv_i}};
endmodule

// File: rtl/hexfp_align.sv
module hexfp_align
  import hexfp_align_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              sub_op_i,
  input  logic              sign_a_i,
  input  logic [CHAR_W-1:0] char_a_i,
  input  logic [FRAC_W-1:0] frac_a_i,
  input  logic              sign_b_i,
  input  logic [CHAR_W-1:0] char_b_i,
  input  logic [FRAC_W-1:0] frac_b_i,
  output logic              out_valid_o,
  output logic [FRAC_W-1:0] aligned_frac_o,
  output logic [FRAC_W-1:0] gated_frac_o,
  output logic [CHAR_W-1:0] res_char_o,
  output logic              eff_sub_o
);
  logic              a_ge_b;
  logic [SH_W-1:0]   shamt;
  logic [FRAC_W-1:0] shift_src, keep_src, shifted, gated;
  logic [CHAR_W-1:0] char_b_n, res_char;
  logic              eff_sub;

  assign char_b_n = ~char_b_i;

  hexfp_exp_cmp #(.CHAR_W(CHAR_W), .DIGITS(DIGITS), .SH_W(SH_W)) i_cmp (
    .char_a_i   (char_a_i),
    .char_b_n_i (char_b_n),
    .a_ge_b_o   (a_ge_b),
    .shamt_o    (shamt)
  );

  assign shift_src = a_ge_b ? frac_b_i : frac_a_i;
  assign keep_src  = a_ge_b ? frac_a_i : frac_b_i;
  assign res_char  = a_ge_b ? char_a_i : char_b_i;
  assign eff_sub   = sign_a_i ^ sign_b_i ^ sub_op_i;

  hexfp_digit_rshift #(.DIGITS(DIGITS), .SH_W(SH_W)) i_shift (
    .din_i   (shift_src),
    .shamt_i (shamt),
    .dout_o  (shifted)
  );

  hexfp_tc_gate #(.FRAC_W(FRAC_W)) i_gate (
    .frac_i (keep_src),
    .inv_i  (eff_sub),
    .frac_o (gated)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_frac_o <= '0;
      gated_frac_o   <= '0;
      res_char_o     <= '0;
      eff_sub_o      <= 1'b0;
    end else if (in_valid_i) begin
      aligned_frac_o <= shifted;
      gated_frac_o   <= gated;
      res_char_o     <= res_char;
      eff_sub_o      <= eff_sub;
    end
  end
endmodule

// File: rtl/hexfp_align_chk.sv
module hexfp_align_chk
  import hexfp_align_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              sub_op_i,
  input logic              sign_a_i,
  input logic [CHAR_W-1:0] char_a_i,
  input logic [FRAC_W-1:0] frac_a_i,
  input logic              sign_b_i,
  input logic [CHAR_W-1:0] char_b_i,
  input logic [FRAC_W-1:0] frac_b_i,
  input logic              out_valid_o,
  input logic [FRAC_W-1:0] aligned_frac_o,
  input logic [FRAC_W-1:0] gated_frac_o,
  input logic [CHAR_W-1:0] res_char_o,
  input logic              eff_sub_o
);
  logic [CHAR_W-1:0] gap;
  logic              big_gap, esub_in;
  assign gap     = (char_a_i >= char_b_i) ? char_a_i - char_b_i : char_b_i - char_a_i;
  assign big_gap = gap > CHAR_W'(DIGITS);
  assign esub_in = sign_a_i ^ sign_b_i ^ sub_op_i;

  assert_valid_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_valid_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  assert_eff_sub_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> eff_sub_o == $past(esub_in));
  assert_res_char_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && char_a_i >= char_b_i |=> res_char_o == $past(char_a_i));
  assert_res_char_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && char_b_i > char_a_i |=> res_char_o == $past(char_b_i));
  assert_equal_path_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && char_a_i == char_b_i |=> aligned_frac_o == $past(frac_b_i));
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && big_gap |=> aligned_frac_o == '0);
  assert_gate_a_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && char_a_i >= char_b_i |=>
      gated_frac_o == ($past(esub_in) ? ~$past(frac_a_i) : $past(frac_a_i)));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(aligned_frac_o) && $stable(gated_frac_o)
                    && $stable(res_char_o) && $stable(eff_sub_o));
endmodule

bind hexfp_align hexfp_align_chk i_chk (.*);

// File: tb/test_hexfp_align.sv
module test_hexfp_align;
  localparam int unsigned FW = 56;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0, sub_op_i = 1'b0, sign_a_i = 1'b0, sign_b_i = 1'b0;
  logic [6:0]    char_a_i = '0, char_b_i = '0;
  logic [FW-1:0] frac_a_i = '0, frac_b_i = '0;
  logic          out_valid_o, eff_sub_o;
  logic [FW-1:0] aligned_frac_o, gated_frac_o;
  logic [6:0]    res_char_o;

  int n_checks = 0, n_fail = 0;
  logic          m_valid = 0, m_esub = 0;
  logic [FW-1:0] m_align = '0, m_gate = '0;
  logic [6:0]    m_char = '0;
  string         m_tag = "R4";

  always #2 clk_i = ~clk_i;

  hexfp_align i_hexfp_align (.*);

  function automatic logic [FW-1:0] rshift_digits(logic [FW-1:0] f, int d);
    return (d > 14) ? '0 : f >> (4 * d);
  endfunction

  task automatic chk(string tag, logic [FW-1:0] act, logic [FW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // check the model state, then apply a new pair and update the model
  task automatic step(logic v, logic so, logic sa, logic [6:0] ca, logic [FW-1:0] fa,
                      logic sb, logic [6:0] cb, logic [FW-1:0] fb);
    @(negedge clk_i);
    chk("R1 valid", FW'(out_valid_o), FW'(m_valid));
    chk("R2 eff_sub", FW'(eff_sub_o), FW'(m_esub));
    chk("R3 res_char", FW'(res_char_o), FW'(m_char));
    chk({m_tag, " aligned"}, aligned_frac_o, m_align);
    chk("R8 gated", gated_frac_o, m_gate);
    in_valid_i = v; sub_op_i = so; sign_a_i = sa; char_a_i = ca; frac_a_i = fa;
    sign_b_i = sb; char_b_i = cb; frac_b_i = fb;
    m_valid = v;
    if (v) begin
      m_esub = sa ^ sb ^ so;
      if (ca >= cb) begin
        m_char  = ca;
        m_align = rshift_digits(fb, int'(ca) - int'(cb));
        m_gate  = m_esub ? ~fa : fa;
        m_tag   = (ca == cb) ? "R6" : (int'(ca) - int'(cb) > 14) ? "R7" : "R4";
      end else begin
        m_char  = cb;
        m_align = rshift_digits(fa, int'(cb) - int'(ca));
        m_gate  = m_esub ? ~fb : fb;
        m_tag   = (int'(cb) - int'(ca) > 14) ? "R7" : "R5";
      end
    end else begin
      m_tag = "R9";
    end
  endtask

  function automatic logic [FW-1:0] rnd_frac();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(4ns * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [FW-1:0] fa, fb;
    int seed_init;
    seed_init = $urandom(32'd91);
    #5;
    // R10: reset state
    chk("R10 valid", FW'(out_valid_o), '0);
    chk("R10 aligned", aligned_frac_o, '0);
    chk("R10 gated", gated_frac_o, '0);
    chk("R10 char", FW'({eff_sub_o, res_char_o}), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    fa = 56'h89ABCDEF012345;
    fb = 56'h123456789ABCDE;
    // directed: equal, 1, 14, 15, max gaps both ways, sign combos
    step(1, 0, 0, 7'd64, fa, 0, 7'd64, fb);  // R6
    step(1, 1, 0, 7'd64, fa, 0, 7'd64, fb);  // R6 + R8 subtract
    step(1, 0, 0, 7'd65, fa, 1, 7'd64, fb);  // R4 one digit
    step(1, 0, 1, 7'd64, fa, 0, 7'd65, fb);  // R5 one digit
    step(1, 1, 1, 7'd78, fa, 0, 7'd64, fb);  // R4 gap 14
    step(1, 0, 0, 7'd79, fa, 0, 7'd64, fb);  // R7 gap 15
    step(1, 0, 1, 7'd10, fa, 1, 7'd24, fb);  // R5 gap 14
    step(1, 1, 0, 7'd10, fa, 1, 7'd25, fb);  // R7
    step(1, 0, 0, 7'd127, fa, 0, 7'd0, fb);  // R7 extreme
    step(1, 0, 0, 7'd0, fa, 0, 7'd127, fb);  // R7 extreme
    step(1, 0, 0, 7'd0, fa, 0, 7'd0, fb);
    step(1, 1, 1, 7'd127, fa, 1, 7'd127, fb);
    step(0, 1, 1, 7'd3, ~fa, 0, 7'd90, ~fb); // R9 hold
    step(0, 0, 0, 7'd90, fb, 1, 7'd3, fa);   // R9 hold
    // R11 back-to-back random, biased to small gaps
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] ca, cb;
      logic v;
      ca = 7'($urandom);
      cb = ($urandom_range(0, 3) != 0) ? 7'(int'(ca) + $urandom_range(0, 32) - 16) : 7'($urandom);
      v  = ($urandom_range(0, 7) != 0);
      step(v, 1'($urandom), 1'($urandom), ca, rnd_frac(), 1'($urandom), cb, rnd_frac());
    end
    step(0, 0, 0, '0, '0, 0, '0, '0);
    step(0, 0, 0, '0, '0, 0, '0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule